// File: doc/BRIEF.md
# UART FIFO Occupancy, Trigger and Receive Time-out Controller

This block tracks how full the receive and transmit data queues of one serial channel are, and turns those fill levels into interrupt requests. It keeps an occupancy counter for each direction. In queued mode each queue holds up to 128 characters. In single-byte mode each holds one character. The receive-data interrupt is raised once the receive count reaches a programmable threshold. The transmit interrupt is raised once the transmit count drains to a threshold of its own, which is set independently.

A control write loads three things at once: the queued-mode enable, the receive threshold code and a transmit threshold code. The transmit code is held pending. It is used only while the enhanced-mode input is high. Otherwise the transmit threshold stays at its post-reset value of 8. A receive time-out keeps a small remainder of characters below the receive threshold from sitting unseen. When received data has gone untouched for a set number of character times, a separate interrupt fires. The serial shifters and the baud generator sit outside this block. They drive the character-received, transmit-load and character-time strobes.

Top module: `uart_fifo_trig`

## Requirements
- R1: After reset both counts are 0, single-byte mode is active, the receive threshold code and the pending transmit code are both 00, `rx_irq` and `rx_tmo_irq` are low and `tx_irq` is high.
- R2: On a cycle with `cfg_wr` high, the block latches `cfg_fifo_en` (1 = queued mode), `cfg_rx_trig` and `cfg_tx_trig`. If the latched mode changes, both counts become 0 on that edge, and any push or pop in that cycle is ignored.
- R3: `rx_push` raises the receive count by one. The count cannot exceed the capacity: 128 in queued mode, 1 in single-byte mode. A push into a full queue is dropped unless `rx_pop` is accepted in the same cycle. `rx_pop` on an empty queue is ignored.
- R4: `tx_push` and `tx_pop` move the transmit count under the same capacity and empty rules as R3.
- R5: Threshold codes map 00→8, 01→16, 10→56, 11→60. In queued mode, `rx_irq` is high exactly when the receive count is at or above the level that the latched receive code selects.
- R6: In single-byte mode, `rx_irq` is high exactly when the receive count is nonzero, and `tx_irq` is high exactly when the transmit count is zero.
- R7: In queued mode, `tx_irq` is high exactly when the transmit count is at or below the active transmit level. That level is the pending code's level while `enh_en` is 1, and 8 while `enh_en` is 0.
- R8: The time-out is armed while queued mode is on and 0 < receive count < receive level. Its counter restarts on any `rx_push` or `rx_pop`. `rx_tmo_irq` is set on the edge of the 4th `char_tick` with no such strobe. It is cleared by `rx_pop`, by `cfg_wr`, or on the edge after the arming condition stops holding.
- R9: A transmit code written while `enh_en` is 0 is kept. Raising `enh_en` later applies it at once, with no rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_fifo_en | input | 1 | Queued-mode enable written by `cfg_wr` |
| cfg_rx_trig | input | 2 | Receive threshold code |
| cfg_tx_trig | input | 2 | Transmit threshold code (held pending) |
| enh_en | input | 1 | Enhanced-mode enable; applies the pending transmit code |
| rx_push | input | 1 | A character has been received |
| rx_pop | input | 1 | The CPU reads a received character |
| tx_push | input | 1 | The CPU writes a character to transmit |
| tx_pop | input | 1 | The transmit shifter takes a character |
| char_tick | input | 1 | One pulse per character time |
| rx_count | output | 8 | Receive queue occupancy |
| tx_count | output | 8 | Transmit queue occupancy |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_tmo_irq | output | 1 | Receive time-out interrupt |

## Verification
The hardest condition to reach from the ports is a time-out that fires on exactly the 4th quiet character time. The receive count must sit strictly inside the window, and a push that came just before must have restarted the count. The bench leaves a few characters below each threshold, issues three ticks, inserts a push to restart, and then counts four more ticks. This shows the interrupt cannot appear early, and that it clears both on a read and on reaching the threshold. The full-queue boundary needs 128 pushes. The bench reaches it in a sweep over all four threshold codes, in which every count from empty to beyond full is compared on every cycle.

// File: rtl/uart_fifo_trig_pkg.sv
package uart_fifo_trig_pkg;

    localparam int TRIG_W = 2;

    // Threshold code to character level
    function automatic int unsigned trig_level(input logic [TRIG_W-1:0] code);
        case (code)
            2'b00:   return 8;
            2'b01:   return 16;
            2'b10:   return 56;
            default: return 60;
        endcase
    endfunction

    typedef struct packed {
        logic              fifo_en;
        logic [TRIG_W-1:0] rx_sel;
        logic [TRIG_W-1:0] tx_pend;
    } trig_cfg_t;

endpackage

// File: rtl/fifo_occ_cnt.sv
module fifo_occ_cnt #(
    parameter int DEPTH = 128,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          byte_mode,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } occ_state_t;

    occ_state_t st_d, st_q;
    logic [CW-1:0] cap;
    logic          dec_ok;
    logic          inc_ok;

    always_comb begin
        cap    = byte_mode ? CW'(1) : CW'(DEPTH);
        dec_ok = dec && (st_q.cnt != '0);
        inc_ok = inc && ((st_q.cnt < cap) || dec_ok);
        st_d   = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(inc_ok) - CW'(dec_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/rx_tmo_timer.sv
module rx_tmo_timer #(
    parameter int TMO_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic restart,
    input  logic clear,
    input  logic tick,
    output logic irq
);

    localparam int TW = $clog2(TMO_CHARS + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          irq;
    } tmo_state_t;

    tmo_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        st_d = st_q;
        fire = armed && !restart && tick && (st_q.cnt == TW'(TMO_CHARS - 1));
        if (!armed || restart) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt < TW'(TMO_CHARS))) begin
            st_d.cnt = st_q.cnt + TW'(1);
        end
        if (!armed || clear) begin
            st_d.irq = 1'b0;
        end else begin
            st_d.irq = st_q.irq | fire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
    import uart_fifo_trig_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int TMO_CHARS   = 4,
    parameter int TX_RST_LVL  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr,
    input  logic                        cfg_fifo_en,
    input  logic [1:0]                  cfg_rx_trig,
    input  logic [1:0]                  cfg_tx_trig,
    input  logic                        enh_en,
    input  logic                        rx_push,
    input  logic                        rx_pop,
    input  logic                        tx_push,
    input  logic                        tx_pop,
    input  logic                        char_tick,
    output logic [$clog2(DEPTH+1)-1:0]  rx_count,
    output logic [$clog2(DEPTH+1)-1:0]  tx_count,
    output logic                        rx_irq,
    output logic                        tx_irq,
    output logic                        rx_tmo_irq
);

    localparam int CW = $clog2(DEPTH + 1);

    trig_cfg_t     cfg_d, cfg_q;
    logic          fifo_en;
    logic          mode_flip;
    logic          ctl_ok;
    logic [CW-1:0] rx_lvl;
    logic [CW-1:0] tx_lvl;
    logic          tmo_armed;

    always_comb begin
        cfg_d     = cfg_q;
        mode_flip = cfg_wr && (cfg_fifo_en != cfg_q.fifo_en);
        if (cfg_wr) begin
            cfg_d.fifo_en = cfg_fifo_en;
            cfg_d.rx_sel  = cfg_rx_trig;
            cfg_d.tx_pend = cfg_tx_trig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fifo_en = cfg_q.fifo_en;
    assign ctl_ok  = !mode_flip;
    assign rx_lvl  = CW'(trig_level(cfg_q.rx_sel));
    assign tx_lvl  = enh_en ? CW'(trig_level(cfg_q.tx_pend)) : CW'(TX_RST_LVL);

    fifo_occ_cnt #(.DEPTH(DEPTH), .CW(CW)) u_rx_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mode_flip),
        .byte_mode (!fifo_en),
        .inc       (rx_push && ctl_ok),
        .dec       (rx_pop && ctl_ok),
        .cnt       (rx_count)
    );

    fifo_occ_cnt #(.DEPTH(DEPTH), .CW(CW)) u_tx_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mode_flip),
        .byte_mode (!fifo_en),
        .inc       (tx_push && ctl_ok),
        .dec       (tx_pop && ctl_ok),
        .cnt       (tx_count)
    );

    assign tmo_armed = fifo_en && (rx_count != '0) && (rx_count < rx_lvl);

    rx_tmo_timer #(.TMO_CHARS(TMO_CHARS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (tmo_armed),
        .restart (rx_push || rx_pop),
        .clear   (rx_pop || cfg_wr),
        .tick    (char_tick),
        .irq     (rx_tmo_irq)
    );

    assign rx_irq = fifo_en ? (rx_count >= rx_lvl) : (rx_count != '0);
    assign tx_irq = fifo_en ? (tx_count <= tx_lvl) : (tx_count == '0);

endmodule

// File: rtl/uart_fifo_trig_chk.sv
module uart_fifo_trig_chk #(
    parameter int DEPTH = 128,
    parameter int CW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          cfg_wr,
    input logic          enh_en,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_irq,
    input logic          tx_irq,
    input logic          rx_tmo_irq
);

    // R3
    rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= (fifo_en ? CW'(DEPTH) : CW'(1)));

    // R4
    tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= (fifo_en ? CW'(DEPTH) : CW'(1)));

    // R3
    rx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0 && rx_pop && !rx_push && !cfg_wr) |=> (rx_count == '0));

    // R8
    tmo_pop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> !rx_tmo_irq);

    // R8
    tmo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_tmo_irq);

    // R7
    tx_def_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_en && fifo_en && tx_count <= CW'(8)) |-> tx_irq);

    // R6
    byte_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_irq == (rx_count != '0)));

endmodule

bind uart_fifo_trig uart_fifo_trig_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .cfg_wr     (cfg_wr),
    .enh_en     (enh_en),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .rx_irq     (rx_irq),
    .tx_irq     (tx_irq),
    .rx_tmo_irq (rx_tmo_irq)
);

// File: tb/uart_fifo_trig_bench.sv
module uart_fifo_trig_bench;

    localparam int CLK_P = 10;
    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_fifo_en = 1'b0;
    logic [1:0] cfg_rx_trig = 2'b00;
    logic [1:0] cfg_tx_trig = 2'b00;
    logic       enh_en = 1'b0;
    logic       rx_push = 1'b0;
    logic       rx_pop = 1'b0;
    logic       tx_push = 1'b0;
    logic       tx_pop = 1'b0;
    logic       char_tick = 1'b0;
    logic [7:0] rx_count;
    logic [7:0] tx_count;
    logic       rx_irq;
    logic       tx_irq;
    logic       rx_tmo_irq;

    uart_fifo_trig u_uart_fifo_trig (
        .clk, .rst_n, .cfg_wr, .cfg_fifo_en, .cfg_rx_trig, .cfg_tx_trig,
        .enh_en, .rx_push, .rx_pop, .tx_push, .tx_pop, .char_tick,
        .rx_count, .tx_count, .rx_irq, .tx_irq, .rx_tmo_irq
    );

    always #(CLK_P/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    int       m_rx = 0, m_tx = 0, m_tc = 0;
    bit       m_fe = 0, m_tmo = 0;
    bit [1:0] m_rs = 0, m_ts = 0;

    function automatic int lvl(input bit [1:0] c);
        return (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 56 : 60;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        int txl;
        txl = enh_en ? lvl(m_ts) : 8;
        chk("R3", "rx_count", int'(rx_count), m_rx);
        chk("R4", "tx_count", int'(tx_count), m_tx);
        if (m_fe) begin
            chk("R5", "rx_irq", int'(rx_irq), int'(m_rx >= lvl(m_rs)));
            chk("R7", "tx_irq", int'(tx_irq), int'(m_tx <= txl));
        end else begin
            chk("R6", "rx_irq", int'(rx_irq), int'(m_rx != 0));
            chk("R6", "tx_irq", int'(tx_irq), int'(m_tx == 0));
        end
        chk("R8", "rx_tmo_irq", int'(rx_tmo_irq), int'(m_tmo));
    endtask

    // one cycle; config values come from cfg_fifo_en/cfg_rx_trig/cfg_tx_trig
    task automatic op(input bit cw, input bit rpu, input bit rpo,
                      input bit tpu, input bit tpo, input bit tk);
        bit armed, flip, rdec, rinc, tdec, tinc, fire;
        int cap;
        @(negedge clk);
        cfg_wr = cw; rx_push = rpu; rx_pop = rpo;
        tx_push = tpu; tx_pop = tpo; char_tick = tk;
        armed = m_fe && m_rx > 0 && m_rx < lvl(m_rs);
        fire  = armed && !(rpu || rpo) && tk && m_tc == 3;
        if (!armed || rpu || rpo) m_tc = 0;
        else if (tk && m_tc < 4) m_tc++;
        m_tmo = (!armed || rpo || cw) ? 0 : (m_tmo | fire);
        flip = cw && (cfg_fifo_en != m_fe);
        if (flip) begin
            m_rx = 0; m_tx = 0;
        end else begin
            cap  = m_fe ? DEPTH : 1;
            rdec = rpo && m_rx > 0;
            rinc = rpu && (m_rx < cap || rdec);
            m_rx = m_rx + int'(rinc) - int'(rdec);
            tdec = tpo && m_tx > 0;
            tinc = tpu && (m_tx < cap || tdec);
            m_tx = m_tx + int'(tinc) - int'(tdec);
        end
        if (cw) begin
            m_fe = cfg_fifo_en; m_rs = cfg_rx_trig; m_ts = cfg_tx_trig;
        end
        @(posedge clk);
        #1;
        cfg_wr = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; char_tick = 0;
        check_all();
    endtask

    task automatic write_cfg(input bit fe, input bit [1:0] rs, input bit [1:0] ts);
        cfg_fifo_en = fe; cfg_rx_trig = rs; cfg_tx_trig = ts;
        op(1, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "rx_count", int'(rx_count), 0);
        chk("R1", "tx_count", int'(tx_count), 0);
        chk("R1", "rx_irq", int'(rx_irq), 0);
        chk("R1", "tx_irq", int'(tx_irq), 1);
        chk("R1", "rx_tmo_irq", int'(rx_tmo_irq), 0);
        @(negedge clk);
        rst_n = 1;

        // R1 reset codes: queued mode on, codes untouched via a write of 00
        write_cfg(1, 0, 0);
        chk("R1", "rx level 8 not reached", int'(rx_irq), 0);

        // R5 R7 R3 R4 sweep over every threshold code, enhanced on
        enh_en = 1;
        for (int s = 0; s < 4; s++) begin
            write_cfg(1, 2'(s), 2'(3 - s));
            for (int i = 0; i < DEPTH + 2; i++) op(0, 1, 0, 1, 0, 0);
            op(0, 1, 1, 1, 1, 0);   // push+pop at full keeps 128
            for (int i = 0; i < DEPTH + 2; i++) op(0, 0, 1, 0, 1, 0);
            op(0, 1, 1, 1, 1, 0);   // push+pop at empty gives 1
            op(0, 0, 1, 0, 1, 0);
        end

        // R7 enhanced off: level 8 regardless of pending code
        enh_en = 0;
        write_cfg(1, 0, 3);
        for (int i = 0; i < 30; i++) op(0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 25; i++) op(0, 0, 0, 0, 1, 0);
        // R9 pending code 11 applies as soon as enh_en rises
        for (int i = 0; i < 20; i++) op(0, 0, 0, 1, 0, 0);
        chk("R9", "tx_irq enh off at 25", int'(tx_irq), 0);
        @(negedge clk);
        enh_en = 1;
        #1;
        chk("R9", "tx_irq enh on at 25", int'(tx_irq), 1);
        op(0, 0, 0, 0, 0, 0);

        // R2 mode change clears both counts, push in same cycle ignored
        for (int i = 0; i < 5; i++) op(0, 1, 0, 0, 0, 0);
        cfg_fifo_en = 0; cfg_rx_trig = 2; cfg_tx_trig = 1;
        op(1, 1, 0, 1, 0, 0);
        chk("R2", "rx cleared", int'(rx_count), 0);
        chk("R2", "tx cleared", int'(tx_count), 0);

        // R6 single-byte mode: capacity 1
        op(0, 1, 0, 1, 0, 0);
        op(0, 1, 0, 1, 0, 0);
        op(0, 1, 1, 0, 1, 0);
        op(0, 0, 1, 0, 0, 0);
        op(0, 0, 1, 0, 0, 0);
        // R8 no time-out in single-byte mode
        op(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) op(0, 0, 0, 0, 0, 1);
        op(0, 0, 1, 0, 0, 0);

        // R8 time-out in queued mode, each threshold code
        for (int s = 0; s < 4; s++) begin
            write_cfg(1, 2'(s), 0);
            for (int i = 0; i < 3; i++) op(0, 1, 0, 0, 0, 0);
            for (int i = 0; i < 3; i++) op(0, 0, 0, 0, 0, 1);
            op(0, 1, 0, 0, 0, 0);               // restart
            for (int i = 0; i < 3; i++) op(0, 0, 0, 0, 0, 1);
            chk("R8", "no early time-out", int'(rx_tmo_irq), 0);
            op(0, 0, 0, 0, 0, 1);
            chk("R8", "time-out on 4th tick", int'(rx_tmo_irq), 1);
            op(0, 0, 0, 0, 0, 1);
            op(0, 0, 1, 0, 0, 0);               // read clears
            for (int i = 0; i < 5; i++) op(0, 0, 0, 0, 0, 1);
            // fill to the threshold: disarms and clears
            for (int i = 0; i < lvl(2'(s)); i++) op(0, 1, 0, 0, 0, 0);
            for (int i = 0; i < 5; i++) op(0, 0, 0, 0, 0, 1);
            chk("R8", "no time-out at level", int'(rx_tmo_irq), 0);
            cfg_fifo_en = 0;
            op(1, 0, 0, 0, 0, 0);
        end

        finish_run();
    end

endmodule